// File: doc/BRIEF.md
# NAND Flash Command Interface Model

This block is a synthesizable device-side responder that behaves like the command logic of a NAND flash memory. It reads one bus event per clock from a host: a command byte, an address byte or a data byte, marked by two latch-select inputs and a write strobe. It keeps a page register and a small modelled array, and it simulates array read and program time with a countdown. While that countdown runs it holds its ready output low. A host controller under test can run complete read, program and status sequences against the block and see the same acceptance rules a real flash part applies.

A page holds a main area followed by a spare area. A program sequence fills the page register, which starts at all ones. The confirm byte then merges the loaded bytes into the array as a bitwise AND, so cells can only move from 1 to 0. Each page counts how many programs have touched its main area and how many have touched its spare area. A program that goes past either limit is blocked. The verify step then reports it, but only if some bit that was meant to be cleared is still set. Status mode is sticky. After the status command, every read strobe returns the status byte until another accepted command is written.

Top module: `nand_cmd_model`

## Requirements
- R1: After rst_n is released, ready is high, every array byte and every page-register byte is FFh, and the fail flag is 0.
- R2: The sequence 00h, column byte, row byte, 30h holds ready low for READ_CYCLES cycles and then copies the addressed page into the page register. Each later read strobe then returns the byte at the current column and advances the column. A column at or past the page size returns FFh and does not advance.
- R3: The sequence 80h, column byte, row byte, one or more data bytes, 10h holds ready low for PROG_CYCLES cycles. Each loaded array byte then becomes its old value ANDed with the loaded value. Data bytes fill consecutive columns.
- R4: Array bytes that were not loaded during a program sequence keep their old value.
- R5: Inside a data-loading phase, 85h followed by one column byte moves the load column. The next data byte lands at that column.
- R6: A 10h with no data byte loaded since the last 80h starts nothing: ready stays high and the array is unchanged.
- R7: While ready is low, only 70h and FFh are accepted. Every other command byte, every address byte and every data byte is ignored.
- R8: After 70h, each read strobe returns the status byte. Bit 6 is ready, bit 0 is the fail flag and the other bits are 0. This lasts until another accepted command other than 70h is written.
- R9: The main area is columns 0 to MAIN_BYTES-1 and the spare area is the columns after it. Each page accepts at most MAX_NOP programs that load a main-area byte and, counted separately, at most MAX_NOP programs that load a spare-area byte. A program past either limit leaves the page unchanged and is not counted.
- R10: After a program, the fail flag is 1 exactly when some loaded bit that was 0 reads back as 1. Loading a 1 over a stored 0 is not flagged. The flag clears when the next 10h is accepted.
- R11: FFh, accepted even while busy, aborts any operation without changing the array. Before the next cycle it sets ready high, sets the page register to FFh, sets the column to 0, clears the fail flag and leaves status mode.
- R12: dout changes only in the cycle after a read strobe and holds otherwise. A read strobe outside status mode while ready is low returns FFh and does not move the column.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| we | input | 1 | Write strobe: one bus byte this cycle |
| re | input | 1 | Read strobe: return one byte on dout next cycle |
| cle | input | 1 | With we, marks din as a command byte |
| ale | input | 1 | With we and not cle, marks din as an address byte |
| din | input | 8 | Bus byte from host |
| dout | output | 8 | Byte returned for the last read strobe |
| ready | output | 1 | High when no read or program time is running |

## Verification
The bench uses several program patterns:
- A first program into an erased page.
- A second program whose AND differs from plain overwrite.
- A load of all ones over cleared bits, which must not be flagged.
- A split load using the column change command.

A run of program operations on one page drives the main-area counter to its limit. A further program past the limit then separates a blocked write that raises fail from a spare-area write that must still succeed. Commands sent during busy time show whether the busy filter and sticky status mode are kept apart. An abort in the middle of a program checks that reset leaves the array untouched.

// File: rtl/nand_model_pkg.sv
package nand_model_pkg;

    localparam logic [7:0] OP_READ     = 8'h00;
    localparam logic [7:0] OP_READ_GO  = 8'h30;
    localparam logic [7:0] OP_PROG     = 8'h80;
    localparam logic [7:0] OP_COLCHG   = 8'h85;
    localparam logic [7:0] OP_PROG_GO  = 8'h10;
    localparam logic [7:0] OP_STATUS   = 8'h70;
    localparam logic [7:0] OP_RESET    = 8'hFF;

    localparam int STAT_READY_BIT = 6;
    localparam int STAT_FAIL_BIT  = 0;

    typedef enum logic [2:0] {
        CMD_NONE,
        CMD_READ,
        CMD_READ_GO,
        CMD_PROG,
        CMD_COLCHG,
        CMD_PROG_GO,
        CMD_STATUS,
        CMD_RESET
    } cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RADDR,
        ST_PADDR,
        ST_PDATA,
        ST_CADDR,
        ST_RBUSY,
        ST_PBUSY
    } state_e;

    typedef struct packed {
        cmd_e cmd;
        logic addr;
        logic data;
    } bus_ev_t;

endpackage

// File: rtl/nand_cmd_decode.sv
module nand_cmd_decode
    import nand_model_pkg::*;
(
    input  logic       we,
    input  logic       cle,
    input  logic       ale,
    input  logic [7:0] din,
    input  logic       busy,
    output bus_ev_t    ev
);

    always_comb begin
        ev.cmd  = CMD_NONE;
        ev.addr = we && ale && !cle && !busy;
        ev.data = we && !ale && !cle && !busy;
        if (we && cle) begin
            case (din)
                OP_STATUS:  ev.cmd = CMD_STATUS;
                OP_RESET:   ev.cmd = CMD_RESET;
                OP_READ:    ev.cmd = busy ? CMD_NONE : CMD_READ;
                OP_READ_GO: ev.cmd = busy ? CMD_NONE : CMD_READ_GO;
                OP_PROG:    ev.cmd = busy ? CMD_NONE : CMD_PROG;
                OP_COLCHG:  ev.cmd = busy ? CMD_NONE : CMD_COLCHG;
                OP_PROG_GO: ev.cmd = busy ? CMD_NONE : CMD_PROG_GO;
                default:    ev.cmd = CMD_NONE;
            endcase
        end
    end

endmodule

// File: rtl/nand_prog_unit.sv
module nand_prog_unit #(
    parameter int MAIN_BYTES  = 32,
    parameter int SPARE_BYTES = 8,
    parameter int MAX_NOP     = 4,
    parameter int NOP_W       = 3
) (
    input  logic [MAIN_BYTES+SPARE_BYTES-1:0][7:0] old_page,
    input  logic [MAIN_BYTES+SPARE_BYTES-1:0][7:0] load_buf,
    input  logic [MAIN_BYTES+SPARE_BYTES-1:0]      loaded,
    input  logic [NOP_W-1:0]                       nop_main,
    input  logic [NOP_W-1:0]                       nop_spare,
    output logic [MAIN_BYTES+SPARE_BYTES-1:0][7:0] new_page,
    output logic                                   fail,
    output logic                                   bump_main,
    output logic                                   bump_spare
);

    localparam int              PB    = MAIN_BYTES + SPARE_BYTES;
    localparam logic [NOP_W-1:0] LIMIT = NOP_W'(MAX_NOP);

    logic          touch_main;
    logic          touch_spare;
    logic          inhibit;
    logic [PB-1:0] miss;

    assign touch_main  = |loaded[MAIN_BYTES-1:0];
    assign touch_spare = |loaded[PB-1:MAIN_BYTES];
    assign inhibit     = (touch_main && (nop_main >= LIMIT)) ||
                         (touch_spare && (nop_spare >= LIMIT));

    for (genvar i = 0; i < PB; i++) begin : g_byte
        always_comb begin
            if (inhibit || !loaded[i]) new_page[i] = old_page[i];
            else                       new_page[i] = old_page[i] & load_buf[i];
            miss[i] = loaded[i] && (|(~load_buf[i] & new_page[i]));
        end
    end

    assign fail       = |miss;
    assign bump_main  = touch_main && !inhibit;
    assign bump_spare = touch_spare && !inhibit;

endmodule

// File: rtl/nand_cmd_model.sv
module nand_cmd_model
    import nand_model_pkg::*;
#(
    parameter int MAIN_BYTES  = 32,
    parameter int SPARE_BYTES = 8,
    parameter int NUM_PAGES   = 4,
    parameter int MAX_NOP     = 4,
    parameter int PROG_CYCLES = 20,
    parameter int READ_CYCLES = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we,
    input  logic       re,
    input  logic       cle,
    input  logic       ale,
    input  logic [7:0] din,
    output logic [7:0] dout,
    output logic       ready
);

    localparam int PAGE_BYTES = MAIN_BYTES + SPARE_BYTES;
    localparam int ROW_W      = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1;
    localparam int COL_W      = $clog2(PAGE_BYTES);
    localparam int NOP_W      = $clog2(MAX_NOP + 1);
    localparam int MAX_CYC    = (PROG_CYCLES > READ_CYCLES) ? PROG_CYCLES : READ_CYCLES;
    localparam int CNT_W      = $clog2(MAX_CYC + 1);
    localparam logic [7:0] PB8 = 8'(PAGE_BYTES);

    typedef logic [PAGE_BYTES-1:0][7:0] page_t;

    typedef struct packed {
        state_e                          st;
        logic [1:0]                      acnt;
        logic [7:0]                      col;
        logic [ROW_W-1:0]                row;
        logic [CNT_W-1:0]                cnt;
        page_t                           pbuf;
        logic [PAGE_BYTES-1:0]           ld;
        logic [NUM_PAGES-1:0][PAGE_BYTES-1:0][7:0] arr;
        logic [NUM_PAGES-1:0][NOP_W-1:0] nopm;
        logic [NUM_PAGES-1:0][NOP_W-1:0] nops;
        logic                            smode;
        logic                            fail;
        logic [7:0]                      dout;
    } regs_t;

    regs_t   q, d;
    bus_ev_t ev;
    logic    busy;
    page_t   prog_page;
    logic    prog_fail, bump_m, bump_s;
    logic [7:0] status_byte;
    logic [COL_W-1:0] cidx;

    assign busy  = (q.st == ST_RBUSY) || (q.st == ST_PBUSY);
    assign cidx  = q.col[COL_W-1:0];
    assign dout  = q.dout;
    assign ready = !busy;

    nand_cmd_decode u_decode (
        .we   (we),
        .cle  (cle),
        .ale  (ale),
        .din  (din),
        .busy (busy),
        .ev   (ev)
    );

    nand_prog_unit #(
        .MAIN_BYTES  (MAIN_BYTES),
        .SPARE_BYTES (SPARE_BYTES),
        .MAX_NOP     (MAX_NOP),
        .NOP_W       (NOP_W)
    ) u_prog (
        .old_page   (q.arr[q.row]),
        .load_buf   (q.pbuf),
        .loaded     (q.ld),
        .nop_main   (q.nopm[q.row]),
        .nop_spare  (q.nops[q.row]),
        .new_page   (prog_page),
        .fail       (prog_fail),
        .bump_main  (bump_m),
        .bump_spare (bump_s)
    );

    always_comb begin
        status_byte                 = '0;
        status_byte[STAT_READY_BIT] = !busy;
        status_byte[STAT_FAIL_BIT]  = q.fail;
    end

    always_comb begin
        d = q;

        // busy countdown and completion of array operations
        if (busy) begin
            if (q.cnt == '0) begin
                if (q.st == ST_RBUSY) begin
                    d.pbuf = q.arr[q.row];
                    d.ld   = '0;
                end else begin
                    d.arr[q.row] = prog_page;
                    d.fail       = prog_fail;
                    if (bump_m) d.nopm[q.row] = q.nopm[q.row] + 1'b1;
                    if (bump_s) d.nops[q.row] = q.nops[q.row] + 1'b1;
                end
                d.st = ST_IDLE;
            end else begin
                d.cnt = q.cnt - 1'b1;
            end
        end

        // read strobe
        if (re) begin
            if (q.smode) begin
                d.dout = status_byte;
            end else if (busy) begin
                d.dout = 8'hFF;
            end else if (q.col < PB8) begin
                d.dout = q.pbuf[cidx];
                d.col  = q.col + 8'd1;
            end else begin
                d.dout = 8'hFF;
            end
        end

        // command bytes
        case (ev.cmd)
            CMD_RESET: begin
                d.st    = ST_IDLE;
                d.acnt  = '0;
                d.col   = '0;
                d.cnt   = '0;
                d.pbuf  = '1;
                d.ld    = '0;
                d.smode = 1'b0;
                d.fail  = 1'b0;
            end
            CMD_STATUS: d.smode = 1'b1;
            CMD_READ: begin
                d.st    = ST_RADDR;
                d.acnt  = '0;
                d.smode = 1'b0;
            end
            CMD_READ_GO: begin
                if (q.st == ST_RADDR && q.acnt == 2'd2) begin
                    d.st    = ST_RBUSY;
                    d.cnt   = CNT_W'(READ_CYCLES - 1);
                    d.smode = 1'b0;
                end
            end
            CMD_PROG: begin
                d.st    = ST_PADDR;
                d.acnt  = '0;
                d.pbuf  = '1;
                d.ld    = '0;
                d.smode = 1'b0;
            end
            CMD_COLCHG: begin
                if (q.st == ST_PDATA) begin
                    d.st    = ST_CADDR;
                    d.smode = 1'b0;
                end
            end
            CMD_PROG_GO: begin
                if (q.st == ST_PDATA && (|q.ld)) begin
                    d.st    = ST_PBUSY;
                    d.cnt   = CNT_W'(PROG_CYCLES - 1);
                    d.fail  = 1'b0;
                    d.smode = 1'b0;
                end
            end
            default: ;
        endcase

        // address bytes
        if (ev.addr) begin
            if (q.st == ST_RADDR || q.st == ST_PADDR) begin
                if (q.acnt == 2'd0) begin
                    d.col  = din;
                    d.acnt = 2'd1;
                end else if (q.acnt == 2'd1) begin
                    d.row  = din[ROW_W-1:0];
                    d.acnt = 2'd2;
                    if (q.st == ST_PADDR) d.st = ST_PDATA;
                end
            end else if (q.st == ST_CADDR) begin
                d.col = din;
                d.st  = ST_PDATA;
            end
        end

        // data bytes
        if (ev.data && q.st == ST_PDATA && q.col < PB8) begin
            d.pbuf[cidx] = din;
            d.ld[cidx]   = 1'b1;
            d.col        = q.col + 8'd1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st    <= ST_IDLE;
            q.acnt  <= '0;
            q.col   <= '0;
            q.row   <= '0;
            q.cnt   <= '0;
            q.pbuf  <= '1;
            q.ld    <= '0;
            q.arr   <= '1;
            q.nopm  <= '0;
            q.nops  <= '0;
            q.smode <= 1'b0;
            q.fail  <= 1'b0;
            q.dout  <= '0;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/nand_cmd_model_chk.sv
module nand_cmd_model_chk
    import nand_model_pkg::*;
#(
    parameter int PB       = 40,
    parameter int ARR_BITS = 1280
) (
    input logic                clk,
    input logic                rst_n,
    input logic                we,
    input logic                re,
    input logic                cle,
    input logic                ale,
    input logic [7:0]          din,
    input logic [7:0]          dout,
    input logic                ready,
    input state_e              st,
    input logic [PB-1:0]       ld,
    input logic [ARR_BITS-1:0] arr,
    input logic                smode
);

    assert_reset_cmd_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (we && cle && din == 8'hFF) |=> (ready && !smode));

    assert_status_ready_bit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (re && smode) |=> (dout[6] == $past(ready)));

    assert_empty_confirm_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && we && cle && !ale && din == 8'h10 && ld == '0) |=> ready);

    assert_busy_filter_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && we && cle && (din == 8'h00 || din == 8'h80 || din == 8'h85 || din == 8'h30))
        |=> (st != ST_RADDR && st != ST_PADDR && st != ST_CADDR));

    assert_only_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((arr & ~$past(arr)) == '0));

    assert_dout_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !re |=> $stable(dout));

endmodule

bind nand_cmd_model nand_cmd_model_chk #(
    .PB       (PAGE_BYTES),
    .ARR_BITS (NUM_PAGES * PAGE_BYTES * 8)
) chk_i (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (we),
    .re    (re),
    .cle   (cle),
    .ale   (ale),
    .din   (din),
    .dout  (dout),
    .ready (ready),
    .st    (q.st),
    .ld    (q.ld),
    .arr   (q.arr),
    .smode (q.smode)
);

// File: tb/nand_cmd_model_tb_top.sv
module nand_cmd_model_tb_top;

    localparam int MAIN  = 32;
    localparam int SPARE = 8;
    localparam int PB    = MAIN + SPARE;
    localparam int NP    = 4;
    localparam int NOP   = 4;
    localparam int TPROG = 20;
    localparam int TREAD = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       we = 1'b0, re = 1'b0, cle = 1'b0, ale = 1'b0;
    logic [7:0] din = 8'h00;
    logic [7:0] dout;
    logic       ready;

    int n_chk = 0;
    int n_err = 0;

    always #2 clk = ~clk;

    nand_cmd_model #(
        .MAIN_BYTES  (MAIN),
        .SPARE_BYTES (SPARE),
        .NUM_PAGES   (NP),
        .MAX_NOP     (NOP),
        .PROG_CYCLES (TPROG),
        .READ_CYCLES (TREAD)
    ) dut_i (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (we),
        .re    (re),
        .cle   (cle),
        .ale   (ale),
        .din   (din),
        .dout  (dout),
        .ready (ready)
    );

    // ---------------- behavioural reference model ----------------
    logic [7:0] m_arr [NP][PB];
    logic [7:0] m_buf [PB];
    logic       m_ld  [PB];
    int         m_nm [NP];
    int         m_ns [NP];
    int         m_st, m_ac, m_col, m_row, m_cnt;
    logic       m_sm, m_fail;
    logic [7:0] m_dout;
    logic       m_busy, o_fail, tm, ts, inh, anyld;
    int         o_st;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int p = 0; p < NP; p++) begin
                for (int c = 0; c < PB; c++) m_arr[p][c] = 8'hFF;
                m_nm[p] = 0;
                m_ns[p] = 0;
            end
            for (int c = 0; c < PB; c++) begin
                m_buf[c] = 8'hFF;
                m_ld[c]  = 1'b0;
            end
            m_st = 0; m_ac = 0; m_col = 0; m_row = 0; m_cnt = 0;
            m_sm = 0; m_fail = 0; m_dout = 8'h00;
        end else begin
            m_busy = (m_st == 5 || m_st == 6);
            o_st   = m_st;
            o_fail = m_fail;
            anyld  = 1'b0;
            for (int c = 0; c < PB; c++) anyld = anyld | m_ld[c];
            if (m_busy) begin
                if (m_cnt == 0) begin
                    if (m_st == 5) begin
                        for (int c = 0; c < PB; c++) begin
                            m_buf[c] = m_arr[m_row][c];
                            m_ld[c]  = 1'b0;
                        end
                    end else begin
                        tm = 0; ts = 0;
                        for (int c = 0; c < PB; c++) begin
                            if (m_ld[c] && c < MAIN) tm = 1;
                            if (m_ld[c] && c >= MAIN) ts = 1;
                        end
                        inh = (tm && m_nm[m_row] >= NOP) || (ts && m_ns[m_row] >= NOP);
                        m_fail = 0;
                        for (int c = 0; c < PB; c++) begin
                            if (m_ld[c] && !inh) m_arr[m_row][c] = m_arr[m_row][c] & m_buf[c];
                            if (m_ld[c] && ((~m_buf[c] & m_arr[m_row][c]) != 8'h00)) m_fail = 1;
                        end
                        if (!inh) begin
                            if (tm) m_nm[m_row]++;
                            if (ts) m_ns[m_row]++;
                        end
                    end
                    m_st = 0;
                end else begin
                    m_cnt--;
                end
            end
            if (re) begin
                if (m_sm) m_dout = {1'b0, !m_busy, 5'b0, o_fail};
                else if (m_busy) m_dout = 8'hFF;
                else if (m_col < PB) begin
                    m_dout = m_buf[m_col];
                    m_col++;
                end else m_dout = 8'hFF;
            end
            if (we && cle) begin
                if (din == 8'h70) m_sm = 1;
                else if (din == 8'hFF) begin
                    m_st = 0; m_ac = 0; m_col = 0; m_cnt = 0; m_sm = 0; m_fail = 0;
                    for (int c = 0; c < PB; c++) begin
                        m_buf[c] = 8'hFF;
                        m_ld[c]  = 1'b0;
                    end
                end else if (!m_busy) begin
                    if (din == 8'h00) begin
                        m_st = 1; m_ac = 0; m_sm = 0;
                    end else if (din == 8'h30 && o_st == 1 && m_ac == 2) begin
                        m_st = 5; m_cnt = TREAD - 1; m_sm = 0;
                    end else if (din == 8'h80) begin
                        m_st = 2; m_ac = 0; m_sm = 0;
                        for (int c = 0; c < PB; c++) begin
                            m_buf[c] = 8'hFF;
                            m_ld[c]  = 1'b0;
                        end
                    end else if (din == 8'h85 && o_st == 3) begin
                        m_st = 4; m_sm = 0;
                    end else if (din == 8'h10 && o_st == 3 && anyld) begin
                        m_st = 6; m_cnt = TPROG - 1; m_fail = 0; m_sm = 0;
                    end
                end
            end
            if (we && ale && !cle && !m_busy) begin
                if (o_st == 1 || o_st == 2) begin
                    if (m_ac == 0) begin
                        m_col = din; m_ac = 1;
                    end else if (m_ac == 1) begin
                        m_row = din % NP; m_ac = 2;
                        if (o_st == 2) m_st = 3;
                    end
                end else if (o_st == 4) begin
                    m_col = din; m_st = 3;
                end
            end
            if (we && !cle && !ale && !m_busy && o_st == 3 && m_col < PB) begin
                m_buf[m_col] = din;
                m_ld[m_col]  = 1'b1;
                m_col++;
            end
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            n_chk++;
            if (dout !== m_dout || ready !== !(m_st == 5 || m_st == 6)) begin
                n_err++;
                $display("FAIL model R2 R3 R8 R12: actual dout=%h ready=%b expected dout=%h ready=%b",
                         dout, ready, m_dout, !(m_st == 5 || m_st == 6));
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cyc(input logic w, input logic r, input logic c, input logic a, input logic [7:0] d);
        @(negedge clk);
        we = w; re = r; cle = c; ale = a; din = d;
    endtask

    task automatic idle1();
        cyc(0, 0, 0, 0, 8'h00);
    endtask

    task automatic cmd(input logic [7:0] v);
        cyc(1, 0, 1, 0, v);
    endtask

    task automatic adr(input logic [7:0] v);
        cyc(1, 0, 0, 1, v);
    endtask

    task automatic dat(input logic [7:0] v);
        cyc(1, 0, 0, 0, v);
    endtask

    task automatic rd_get(output logic [7:0] v);
        cyc(0, 1, 0, 0, 8'h00);
        idle1();
        v = dout;
    endtask

    task automatic wait_ready(output int n);
        n = 0;
        idle1();
        while (!ready) begin
            n++;
            idle1();
        end
    endtask

    task automatic program1(input int row, input int col, input logic [7:0] v);
        int n;
        cmd(8'h80); adr(8'(col)); adr(8'(row)); dat(v); cmd(8'h10);
        wait_ready(n);
    endtask

    task automatic open_page(input int row, input int col, output int n);
        cmd(8'h00); adr(8'(col)); adr(8'(row)); cmd(8'h30);
        wait_ready(n);
    endtask

    task automatic read_stat(output logic [7:0] v);
        cmd(8'h70);
        rd_get(v);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [7:0] v, hold;
        int n;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        idle1();

        // R1: reset state
        chk("R1 ready after reset", {7'b0, ready}, 8'h01);
        read_stat(v);
        chk("R1 R8 status after reset", v, 8'h40);
        open_page(0, 0, n);
        rd_get(v);
        chk("R1 erased array byte", v, 8'hFF);

        // R3: first program and busy time
        cmd(8'h80); adr(8'h00); adr(8'h01); dat(8'hA5); dat(8'h3C); cmd(8'h10);
        wait_ready(n);
        chk("R3 program busy cycles", 8'(n), 8'(TPROG));
        open_page(1, 0, n);
        chk("R2 read busy cycles", 8'(n), 8'(TREAD));
        rd_get(v); chk("R3 byte0", v, 8'hA5);
        rd_get(v); chk("R3 byte1", v, 8'h3C);
        rd_get(v); chk("R4 unloaded byte2", v, 8'hFF);

        // R3 AND merge, R10 pass
        program1(1, 0, 8'h0F);
        read_stat(v); chk("R10 clean program status", v, 8'h40);
        open_page(1, 0, n);
        rd_get(v); chk("R3 AND merge", v, 8'h05);

        // R10: ones over zeros are not flagged
        program1(1, 1, 8'hFF);
        read_stat(v); chk("R10 raise not flagged", v, 8'h40);
        open_page(1, 1, n);
        rd_get(v); chk("R10 byte kept", v, 8'h3C);

        // R5: column change during load
        cmd(8'h80); adr(8'h00); adr(8'h02); dat(8'h11);
        cmd(8'h85); adr(8'h0A); dat(8'h22); cmd(8'h10);
        wait_ready(n);
        open_page(2, 0, n);
        rd_get(v); chk("R5 first byte", v, 8'h11);
        rd_get(v); chk("R4 skipped column", v, 8'hFF);
        open_page(2, 10, n);
        rd_get(v); chk("R5 moved column", v, 8'h22);

        // R6: confirm without data
        cmd(8'h80); adr(8'h00); adr(8'h03); cmd(8'h10);
        idle1();
        chk("R6 no busy", {7'b0, ready}, 8'h01);

        // R7, R8: commands during busy
        cmd(8'h80); adr(8'h00); adr(8'h03); dat(8'h7E); cmd(8'h10);
        cmd(8'h70);
        rd_get(v); chk("R8 status busy", v, 8'h00);
        cmd(8'h00); adr(8'h05); dat(8'h00);
        rd_get(v); chk("R7 R8 still status mode", v, 8'h00);
        wait_ready(n);
        rd_get(v); chk("R8 sticky status ready", v, 8'h40);
        open_page(3, 0, n);
        rd_get(v); chk("R7 busy bytes ignored", v, 8'h7E);
        rd_get(v); chk("R7 busy data ignored", v, 8'hFF);

        // R9: main-area limit
        program1(3, 0, 8'hFD);
        program1(3, 0, 8'hFB);
        program1(3, 0, 8'hF7);
        read_stat(v); chk("R9 fourth program ok", v, 8'h40);
        program1(3, 0, 8'h0F);
        read_stat(v); chk("R9 R10 over limit fails", v, 8'h41);
        open_page(3, 0, n);
        rd_get(v); chk("R9 page unchanged", v, 8'h70);
        program1(3, MAIN, 8'h5A);
        read_stat(v); chk("R9 R10 spare separate", v, 8'h40);
        open_page(3, MAIN, n);
        rd_get(v); chk("R9 spare written", v, 8'h5A);

        // R2: end of page
        program1(2, PB - 1, 8'hC3);
        open_page(2, PB - 1, n);
        rd_get(v); chk("R2 last column", v, 8'hC3);
        rd_get(v); chk("R2 past end", v, 8'hFF);

        // R12: hold and busy read
        hold = dout;
        idle1(); idle1(); idle1();
        chk("R12 dout holds", dout, hold);
        cmd(8'h00); adr(8'h00); adr(8'h02); cmd(8'h30);
        rd_get(v); chk("R12 busy read", v, 8'hFF);
        wait_ready(n);
        rd_get(v); chk("R12 column kept", v, 8'h11);

        // R11: abort
        cmd(8'h80); adr(8'h07); adr(8'h00); dat(8'h00); cmd(8'h10);
        idle1(); idle1();
        cmd(8'hFF);
        idle1();
        chk("R11 ready after reset cmd", {7'b0, ready}, 8'h01);
        rd_get(v); chk("R11 page register cleared", v, 8'hFF);
        read_stat(v); chk("R11 status", v, 8'h40);
        open_page(0, 7, n);
        rd_get(v); chk("R11 program aborted", v, 8'hFF);

        repeat (3) idle1();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule